// File: doc/BRIEF.md
# PCM Receive Time-Slot Deserializer

This block collects one 8-bit companded voice sample from a serial receive line. It runs entirely on a fast master clock. The bit clock, the receive frame sync and the serial data are brought into that domain as ordinary inputs, and falling bit-clock edges are found by edge detection. Capture begins at a point set by the frame-sync mode, and this block does not work out that mode. It comes in as a level from the transmit-side logic, which classifies its own sync pulse width as short or long.

Once eight bits have been shifted in, most significant (sign) bit first, the assembled word appears on a parallel output together with a one-cycle valid pulse. That pulse also starts a timer. The timer raises an update strobe a fixed time later, which marks the moment a downstream decoder output would change. The default delay is 10 µs at a 2.048 MHz master clock. Power-down stops any capture in progress and silences the strobe. Expansion to linear samples and everything analog stay outside this block.

Top module: `pcm_rx_deser`

## Requirements
- R1: After reset, `word_out` is 0, and `word_vld` and `upd_strobe` are low.
- R2: With `long_mode` low, a falling bit-clock edge that sees the frame sync high arms the slot. The next eight falling edges then sample `sdata_in`. The first sample lands in bit 7 of the word and the last in bit 0.
- R3: With `long_mode` high, a rising edge of the frame sync arms the slot. The next eight falling bit-clock edges, counting the one in the same bit period, sample the data MSB first.
- R4: The start rule comes only from `long_mode`. Take one waveform whose sync is high for one bit period, with bit value A in that period followed by word W. It yields W when `long_mode` is low and {A, W[7:1]} when it is high.
- R5: `word_out` changes only when the eighth bit is taken. It then changes together with a `word_vld` pulse that lasts exactly one master-clock cycle. While a slot is in progress, `word_out` keeps the previous word.
- R6: If `pwr_down` rises during a slot, the slot is abandoned. No `word_vld` follows, and `word_out` keeps the previous word.
- R7: While `pwr_down` is high, no slot starts. A pending update strobe is cancelled, so no `upd_strobe` appears.
- R8: `upd_strobe` pulses for one cycle, exactly ceil(MCLK_KHZ*UPD_NS/10^6) master-clock cycles after the `word_vld` cycle. With the defaults this is 21 cycles.
- R9: In long mode, a frame sync that falls and rises again while a slot is in progress is ignored. The slot still delivers the original eight bits as one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous to `clk` |
| fsync_in | input | 1 | Receive frame-sync pulse |
| sdata_in | input | 1 | Serial receive data |
| long_mode | input | 1 | 1 = long-pulse framing, 0 = short-pulse framing (from transmit side) |
| pwr_down | input | 1 | 1 = block idle, capture and strobe suppressed |
| word_out | output | WORD_W | Last completed received word |
| word_vld | output | 1 | One-cycle pulse when `word_out` updates |
| upd_strobe | output | 1 | Delayed decoder-update strobe |

## Verification
`word_vld` goes high a few master cycles after the eighth falling bit-clock edge. That lag comes from the synchronizer, the edge register and the commit register. `upd_strobe` follows `word_vld` by exactly 21 cycles. The bench therefore does not guess the first latency. It counts `word_vld` pulses and records each word on the falling master-clock edge, and it checks these only after several idle bit periods. The strobe delay is measured exactly: a counter restarts at each `word_vld` and is compared against 21 when the strobe is seen.

// File: rtl/pcm_rx_pkg.sv
// Shared types for the PCM receive deserializer.
package pcm_rx_pkg;

    // Slot capture state
    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    // Integer ceiling division used for time-to-cycle conversion.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
// Brings bit clock, frame sync and data into the master-clock domain.
// Assumes all three inputs are slow relative to clk. Every input passes
// through the same number of stages, so data stays aligned with the
// detected bit-clock edges.
module pcm_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_raw,
    input  logic fs_raw,
    input  logic sd_raw,
    output logic bclk_fall,
    output logic fs_level,
    output logic fs_rise,
    output logic sd_bit
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] bclk_sr, fs_sr, sd_sr;
    logic         bclk_d, fs_d;

    // Synchronizer chains plus one delayed copy each for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_sr <= '0;
            fs_sr   <= '0;
            sd_sr   <= '0;
            bclk_d  <= 1'b0;
            fs_d    <= 1'b0;
        end else begin
            bclk_sr <= {bclk_sr[TOP-1:0], bclk_raw};
            fs_sr   <= {fs_sr[TOP-1:0], fs_raw};
            sd_sr   <= {sd_sr[TOP-1:0], sd_raw};
            bclk_d  <= bclk_sr[TOP];
            fs_d    <= fs_sr[TOP];
        end
    end

    // Edge and level outputs
    always_comb begin
        bclk_fall = bclk_d & ~bclk_sr[TOP];
        fs_rise   = ~fs_d & fs_sr[TOP];
        fs_level  = fs_sr[TOP];
        sd_bit    = sd_sr[TOP];
    end

endmodule

// File: rtl/pcm_rx_slot.sv
// Slot capture state machine. Arms on the start event chosen by
// long_mode, shifts in WORD_W bits MSB first on falling bit-clock edges
// and commits them to the output register only when the slot completes.
// Assumes pwr_down is synchronous to clk.
module pcm_rx_slot
    import pcm_rx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              long_mode,
    input  logic              bclk_fall,
    input  logic              fs_level,
    input  logic              fs_rise,
    input  logic              sd_bit,
    output logic [WORD_W-1:0] word_q,
    output logic              word_vld
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic              start_ev;
    logic [WORD_W-1:0] shreg_nxt;

    // Start event: sync edge in long mode, sync level at a falling edge in short mode
    always_comb begin
        start_ev  = long_mode ? fs_rise : (bclk_fall & fs_level);
        shreg_nxt = {shreg[WORD_W-2:0], sd_bit};
    end

    // Arm, shift and commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            word_q   <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (pwr_down) begin
                state   <= RX_IDLE;
                bit_cnt <= '0;
            end else begin
                case (state)
                    RX_IDLE: begin
                        if (start_ev) begin
                            state   <= RX_SHIFT;
                            bit_cnt <= '0;
                        end
                    end
                    RX_SHIFT: begin
                        if (bclk_fall) begin
                            shreg   <= shreg_nxt;
                            bit_cnt <= bit_cnt + CNT_W'(1);
                            if (bit_cnt == LAST_BIT) begin
                                word_q   <= shreg_nxt;
                                word_vld <= 1'b1;
                                state    <= RX_IDLE;
                            end
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R5
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q != $past(word_q)) |-> word_vld);

    // R6
    pdn_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_down) |-> !word_vld);

    // R2
    vld_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(bclk_fall));

endmodule

// File: rtl/pcm_rx_upd_timer.sv
// Decoder-update delay timer. Restarted by each completed word, it emits
// a one-cycle strobe DLY cycles later. Power-down clears it.
// Assumes DLY >= 1.
module pcm_rx_upd_timer #(
    parameter int DLY = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic start,
    output logic strobe
);
    localparam int CNT_W = $clog2(DLY + 1);

    logic [CNT_W-1:0] cnt_q;

    // Countdown register
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(DLY);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Strobe on the final count, held off during power-down
    always_comb strobe = (cnt_q == CNT_W'(1)) && !pwr_down;

    // R8
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R7
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_down) |-> !strobe);

endmodule

// File: rtl/pcm_rx_deser.sv
// Top of the PCM receive time-slot deserializer: synchronizer, slot
// capture and decoder-update timer. The framing mode is an input
// supplied by transmit-side sync classification.
module pcm_rx_deser
    import pcm_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WORD_W      = 8,
    parameter int MCLK_KHZ    = 2048,
    parameter int UPD_NS      = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_in,
    input  logic              fsync_in,
    input  logic              sdata_in,
    input  logic              long_mode,
    input  logic              pwr_down,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              upd_strobe
);
    localparam int UPD_CYC = ceil_div(MCLK_KHZ * UPD_NS, 1000000);

    logic bclk_fall, fs_level, fs_rise, sd_bit;

    pcm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_raw  (bclk_in),
        .fs_raw    (fsync_in),
        .sd_raw    (sdata_in),
        .bclk_fall (bclk_fall),
        .fs_level  (fs_level),
        .fs_rise   (fs_rise),
        .sd_bit    (sd_bit)
    );

    pcm_rx_slot #(.WORD_W(WORD_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .long_mode (long_mode),
        .bclk_fall (bclk_fall),
        .fs_level  (fs_level),
        .fs_rise   (fs_rise),
        .sd_bit    (sd_bit),
        .word_q    (word_out),
        .word_vld  (word_vld)
    );

    pcm_rx_upd_timer #(.DLY(UPD_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .start    (word_vld),
        .strobe   (upd_strobe)
    );

    // R7
    pdn_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_down) |-> !word_vld);

endmodule

// File: tb/sim_pcm_rx_deser.sv
// Directed bench for pcm_rx_deser, one task per scenario.
module sim_pcm_rx_deser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_in = 1'b0, fsync_in = 1'b0, sdata_in = 1'b0;
    logic       long_mode = 1'b0, pwr_down = 1'b0;
    logic [7:0] word_out;
    logic       word_vld, upd_strobe;

    localparam int HALF_BIT = 8;
    // 10 us at 2048 kHz = 20.48 -> 21 cycles
    localparam int EXP_DLY  = 21;

    int tests = 0, fails = 0, cyc = 0;
    int vld_cnt = 0, strb_cnt = 0, since_vld = 0, last_dly = 0, wide_vld = 0;
    logic prev_vld = 1'b0;

    always #2 clk = ~clk;

    pcm_rx_deser u0 (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fsync_in(fsync_in),
        .sdata_in(sdata_in), .long_mode(long_mode), .pwr_down(pwr_down),
        .word_out(word_out), .word_vld(word_vld), .upd_strobe(upd_strobe)
    );

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_vld) begin
                vld_cnt++;
                since_vld = 0;
            end else begin
                since_vld++;
            end
            if (word_vld && prev_vld) wide_vld++;
            if (upd_strobe) begin
                strb_cnt++;
                last_dly = since_vld;
            end
            prev_vld = word_vld;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog all-R actual=%0d expected<%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bit_period(input logic fs, input logic d);
        @(negedge clk);
        bclk_in = 1'b1; fsync_in = fs; sdata_in = d;
        wait_clk(HALF_BIT);
        bclk_in = 1'b0;
        wait_clk(HALF_BIT);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bit_period(1'b0, 1'b0);
    endtask

    // Sync period carrying bit a, then word w
    task automatic send_short(input logic a, input logic [7:0] w);
        bit_period(1'b1, a);
        for (int k = 0; k < 8; k++) bit_period(1'b0, w[7-k]);
    endtask

    task automatic send_long(input logic [7:0] w, input logic [7:0] fs_pat);
        idle(1);
        for (int k = 0; k < 8; k++) bit_period(fs_pat[7-k], w[7-k]);
    endtask

    task automatic t_reset();
        chk("R1 word_out", int'(word_out), 0);
        chk("R1 word_vld", int'(word_vld), 0);
        chk("R1 upd_strobe", int'(upd_strobe), 0);
    endtask

    task automatic t_short(input logic [7:0] w);
        int v0, s0;
        v0 = vld_cnt; s0 = strb_cnt;
        long_mode = 1'b0;
        send_short(1'b0, w);
        idle(3);
        chk("R2 short word", int'(word_out), int'(w));
        chk("R5 one vld", vld_cnt - v0, 1);
        chk("R8 one strobe", strb_cnt - s0, 1);
        chk("R8 strobe delay", last_dly, EXP_DLY);
    endtask

    task automatic t_long(input logic [7:0] w);
        int v0;
        v0 = vld_cnt;
        long_mode = 1'b1;
        send_long(w, 8'b1110_0000);
        idle(3);
        chk("R3 long word", int'(word_out), int'(w));
        chk("R3 one vld", vld_cnt - v0, 1);
    endtask

    task automatic t_mode();
        long_mode = 1'b1;
        send_short(1'b1, 8'h4E);
        idle(3);
        chk("R4 long rule on short pulse", int'(word_out), 8'hA7);
        long_mode = 1'b0;
        send_short(1'b1, 8'h4E);
        idle(3);
        chk("R4 short rule on short pulse", int'(word_out), 8'h4E);
    endtask

    task automatic t_abort();
        logic [7:0] prev;
        int v0;
        long_mode = 1'b0;
        prev = word_out; v0 = vld_cnt;
        bit_period(1'b1, 1'b0);
        for (int k = 0; k < 4; k++) bit_period(1'b0, k[0]);
        chk("R5 word held mid-slot", int'(word_out), int'(prev));
        pwr_down = 1'b1;
        bit_period(1'b0, 1'b1);
        bit_period(1'b0, 1'b1);
        pwr_down = 1'b0;
        idle(3);
        chk("R6 no vld after abort", vld_cnt - v0, 0);
        chk("R6 word kept", int'(word_out), int'(prev));
    endtask

    task automatic t_pdn();
        logic [7:0] prev;
        int v0, s0;
        long_mode = 1'b0;
        prev = word_out; v0 = vld_cnt;
        pwr_down = 1'b1;
        send_short(1'b0, 8'hC3);
        idle(2);
        pwr_down = 1'b0;
        idle(1);
        chk("R7 no capture in pdn", vld_cnt - v0, 0);
        chk("R7 word kept in pdn", int'(word_out), int'(prev));
        // Strobe suppression: power down between word_vld and strobe
        s0 = strb_cnt; v0 = vld_cnt;
        send_short(1'b0, 8'h5A);
        while (vld_cnt == v0) @(negedge clk);
        wait_clk(5);
        pwr_down = 1'b1;
        wait_clk(40);
        pwr_down = 1'b0;
        wait_clk(40);
        chk("R7 word captured", int'(word_out), 8'h5A);
        chk("R7 strobe cancelled", strb_cnt - s0, 0);
    endtask

    task automatic t_resync();
        int v0;
        v0 = vld_cnt;
        long_mode = 1'b1;
        send_long(8'h3B, 8'b1100_1100);
        idle(3);
        chk("R9 re-sync ignored word", int'(word_out), 8'h3B);
        chk("R9 re-sync one vld", vld_cnt - v0, 1);
    endtask

    initial begin
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_short(8'hA5);
        t_short(8'h3C);
        t_long(8'h96);
        t_long(8'h01);
        t_mode();
        t_abort();
        t_pdn();
        t_resync();
        t_short(8'hFF);
        chk("R5 vld width", wide_vld, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule